// File: doc/BRIEF.md
# Word-Windowed LEB128 Unsigned Decoder

This block turns unsigned LEB128 variable-length integers into fixed-width binary values. Its input is a memory word of several bytes together with a byte pointer that marks where the encoded number begins inside that word. Each byte holds seven payload bits in its low bits, and bit 7 is the continuation flag. Groups are placed least significant first, so group g lands at bit offset 7g of the result. In one cycle the block consumes bytes from the pointer upward. It stops at the first byte whose bit 7 is clear. It then returns the value and the index of the byte that follows.

An encoding may run past the last byte of the word. In that case the block reports the partial value and raises a "need next word" flag. It also returns pointer 0 and keeps the partial value and its bit offset in internal registers. The caller then presents the next word at pointer 0 with the continue input high, and decoding resumes from the saved state. Payload bits above the output width are dropped and raise an overflow flag. If the pointer is tied to 0 and the word is wider than the longest encoding, every number completes in a single cycle, and the flag becomes an error indicator.

Top module: `leb128_word_dec`

## Requirements
- R1: A byte's bits 6:0 are payload and its bit 7 set means another byte follows. Group g of a number is placed at result bits 7g upward. Decoding E5, 8E, 26 gives 0x00098765.
- R2: Byte k of `word_i` is bits 8k+7:8k. Decoding starts at byte `ptr_i`, and bytes below `ptr_i` or after the terminating byte have no effect on the result.
- R3: On completion, `ptr_o` equals the index one past the terminating byte, modulo IN_BYTES.
- R4: If the word ends while bit 7 of the last consumed byte is still set, the next cycle shows `more_o`=1, `valid_o`=0 and `ptr_o`=0. `value_o` then holds the partial value of the groups consumed so far.
- R5: A strobe with `cont_i`=1 resumes from the saved partial value and bit offset, and a number may span any count of words.
- R6: A strobe with `cont_i`=0 starts a fresh number and discards any saved partial state.
- R7: Payload bits at or above bit OUT_BYTES*8 are dropped, and `value_o` keeps the low bits. `ovf_o` is 1 if any dropped bit is 1. It stays set across words until the number completes.
- R8: The outputs are registered with one cycle of latency. `valid_o` and `more_o` never coincide. A cycle with no strobe leaves `valid_o`, `more_o` and `ovf_o` at 0 on the next cycle, and `value_o` and `ptr_o` unchanged.
- R9: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Strobe: decode from this word this cycle |
| cont_i | input | 1 | 1 = resume saved partial number, 0 = new number |
| word_i | input | 8*IN_BYTES | Input word, byte k at bits 8k+7:8k |
| ptr_i | input | $clog2(IN_BYTES) | Index of the first byte to consume |
| value_o | output | 8*OUT_BYTES | Decoded (or partial) value |
| ptr_o | output | $clog2(IN_BYTES) | Next byte index after the number, 0 on wrap |
| more_o | output | 1 | Number not finished, next word needed |
| ovf_o | output | 1 | Significant bits beyond output width seen |
| valid_o | output | 1 | Completed value present |

## Verification
On every cycle the assertions check the output relations that need no knowledge of the data. `valid_o` and `more_o` are exclusive, and a wrap always returns pointer 0. Overflow is only raised together with a result. After an idle cycle the flags drop and the value holds. The decoded values, the end pointers, the carrying of partial values across words and the discarding of state on a fresh start depend on the byte contents. Only the bench's scenarios can show these. The bench encodes reference numbers at random offsets, with random filler bytes and redundant padding groups, and compares the outputs with what the encoder put in.

// File: rtl/leb_pkg.sv
package leb_pkg;
  localparam int unsigned LEB_GRP_W  = 7;
  localparam int unsigned LEB_CONT_B = 7;
endpackage

// File: rtl/leb_byte_step.sv
module leb_byte_step #(
  parameter int unsigned OUT_W = 32,
  parameter int unsigned SH_W  = 6
) (
  input  logic [7:0]       byte_i,
  input  logic             take_i,
  input  logic [OUT_W-1:0] acc_i,
  input  logic [SH_W-1:0]  sh_i,
  input  logic             ovf_i,
  output logic [OUT_W-1:0] acc_o,
  output logic [SH_W-1:0]  sh_o,
  output logic             ovf_o,
  output logic             last_o
);
  import leb_pkg::*;

  localparam logic [SH_W:0] SH_LIM = (SH_W+1)'(OUT_W);
  localparam logic [SH_W:0] SH_INC = (SH_W+1)'(LEB_GRP_W);

  logic [OUT_W+LEB_GRP_W-1:0] ext;
  logic [SH_W:0]              sh_sum;

  // offset saturates at OUT_W, so the group then lands wholly in the dropped slice
  always_comb begin
    ext    = {{OUT_W{1'b0}}, byte_i[LEB_GRP_W-1:0]} << sh_i;
    sh_sum = {1'b0, sh_i} + SH_INC;
    if (take_i) begin
      acc_o = acc_i | ext[OUT_W-1:0];
      ovf_o = ovf_i | (|ext[OUT_W+LEB_GRP_W-1:OUT_W]);
      sh_o  = (sh_sum > SH_LIM) ? SH_LIM[SH_W-1:0] : sh_sum[SH_W-1:0];
    end else begin
      acc_o = acc_i;
      ovf_o = ovf_i;
      sh_o  = sh_i;
    end
    last_o = take_i & ~byte_i[LEB_CONT_B];
  end
endmodule

// File: rtl/leb_scan.sv
module leb_scan #(
  parameter int unsigned IN_BYTES = 8,
  parameter int unsigned PTR_W    = 3,
  parameter int unsigned OUT_W    = 32,
  parameter int unsigned SH_W     = 6
) (
  input  logic [8*IN_BYTES-1:0] word_i,
  input  logic [PTR_W-1:0]      ptr_i,
  input  logic [OUT_W-1:0]      acc_i,
  input  logic [SH_W-1:0]       sh_i,
  input  logic                  ovf_i,
  output logic [OUT_W-1:0]      acc_o,
  output logic [SH_W-1:0]       sh_o,
  output logic                  ovf_o,
  output logic                  done_o,
  output logic [PTR_W-1:0]      end_ptr_o
);
  logic [OUT_W-1:0]    acc_c [IN_BYTES+1];
  logic [SH_W-1:0]     sh_c  [IN_BYTES+1];
  logic [IN_BYTES:0]   ovf_c;
  logic [IN_BYTES:0]   live_c;
  logic [IN_BYTES-1:0] term;

  assign acc_c[0]  = acc_i;
  assign sh_c[0]   = sh_i;
  assign ovf_c[0]  = ovf_i;
  assign live_c[0] = 1'b1;

  for (genvar k = 0; k < IN_BYTES; k++) begin : g_byte
    logic take;
    assign take = live_c[k] & (PTR_W'(k) >= ptr_i);
    leb_byte_step #(.OUT_W(OUT_W), .SH_W(SH_W)) u_step (
      .byte_i (word_i[8*k +: 8]),
      .take_i (take),
      .acc_i  (acc_c[k]),
      .sh_i   (sh_c[k]),
      .ovf_i  (ovf_c[k]),
      .acc_o  (acc_c[k+1]),
      .sh_o   (sh_c[k+1]),
      .ovf_o  (ovf_c[k+1]),
      .last_o (term[k])
    );
    assign live_c[k+1] = live_c[k] & ~term[k];
  end

  // term is one-hot or zero: the chain dies at the first terminator
  always_comb begin
    end_ptr_o = '0;
    for (int k = 0; k < IN_BYTES; k++)
      if (term[k]) end_ptr_o = end_ptr_o | PTR_W'((k + 1) % IN_BYTES);
  end

  assign acc_o  = acc_c[IN_BYTES];
  assign sh_o   = sh_c[IN_BYTES];
  assign ovf_o  = ovf_c[IN_BYTES];
  assign done_o = |term;
endmodule

// File: rtl/leb_carry_state.sv
module leb_carry_state #(
  parameter int unsigned OUT_W = 32,
  parameter int unsigned SH_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cont_i,
  input  logic             save_i,
  input  logic [OUT_W-1:0] acc_i,
  input  logic [SH_W-1:0]  sh_i,
  input  logic             ovf_i,
  output logic [OUT_W-1:0] base_acc_o,
  output logic [SH_W-1:0]  base_sh_o,
  output logic             base_ovf_o
);
  logic [OUT_W-1:0] sav_acc_q;
  logic [SH_W-1:0]  sav_sh_q;
  logic             sav_ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sav_acc_q <= '0;
      sav_sh_q  <= '0;
      sav_ovf_q <= 1'b0;
    end else if (start_i) begin
      sav_acc_q <= save_i ? acc_i : '0;
      sav_sh_q  <= save_i ? sh_i  : '0;
      sav_ovf_q <= save_i & ovf_i;
    end
  end

  assign base_acc_o = cont_i ? sav_acc_q : '0;
  assign base_sh_o  = cont_i ? sav_sh_q  : '0;
  assign base_ovf_o = cont_i & sav_ovf_q;
endmodule

// File: rtl/leb128_word_dec.sv
module leb128_word_dec #(
  parameter int unsigned IN_BYTES  = 8,
  parameter int unsigned OUT_BYTES = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic                          cont_i,
  input  logic [8*IN_BYTES-1:0]         word_i,
  input  logic [$clog2(IN_BYTES)-1:0]   ptr_i,
  output logic [8*OUT_BYTES-1:0]        value_o,
  output logic [$clog2(IN_BYTES)-1:0]   ptr_o,
  output logic                          more_o,
  output logic                          ovf_o,
  output logic                          valid_o
);
  localparam int unsigned PTR_W = $clog2(IN_BYTES);
  localparam int unsigned OUT_W = 8 * OUT_BYTES;
  localparam int unsigned SH_W  = $clog2(OUT_W + 1);

  logic [OUT_W-1:0] base_acc, scan_acc;
  logic [SH_W-1:0]  base_sh, scan_sh;
  logic             base_ovf, scan_ovf, scan_done;
  logic [PTR_W-1:0] scan_end;

  leb_carry_state #(.OUT_W(OUT_W), .SH_W(SH_W)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .cont_i     (cont_i),
    .save_i     (~scan_done),
    .acc_i      (scan_acc),
    .sh_i       (scan_sh),
    .ovf_i      (scan_ovf),
    .base_acc_o (base_acc),
    .base_sh_o  (base_sh),
    .base_ovf_o (base_ovf)
  );

  leb_scan #(.IN_BYTES(IN_BYTES), .PTR_W(PTR_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_scan (
    .word_i    (word_i),
    .ptr_i     (ptr_i),
    .acc_i     (base_acc),
    .sh_i      (base_sh),
    .ovf_i     (base_ovf),
    .acc_o     (scan_acc),
    .sh_o      (scan_sh),
    .ovf_o     (scan_ovf),
    .done_o    (scan_done),
    .end_ptr_o (scan_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      value_o <= '0;
      ptr_o   <= '0;
      more_o  <= 1'b0;
      ovf_o   <= 1'b0;
      valid_o <= 1'b0;
    end else if (start_i) begin
      value_o <= scan_acc;
      ptr_o   <= scan_done ? scan_end : '0;
      more_o  <= ~scan_done;
      ovf_o   <= scan_ovf;
      valid_o <= scan_done;
    end else begin
      more_o  <= 1'b0;
      ovf_o   <= 1'b0;
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/leb128_word_dec_chk.sv
module leb128_word_dec_chk #(
  parameter int unsigned IN_BYTES  = 8,
  parameter int unsigned OUT_BYTES = 4
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        start_i,
  input logic [8*OUT_BYTES-1:0]      value_o,
  input logic [$clog2(IN_BYTES)-1:0] ptr_o,
  input logic                        more_o,
  input logic                        ovf_o,
  input logic                        valid_o
);
  a_r8_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && more_o));

  a_r4_wrap_ptr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    more_o |-> (ptr_o == '0));

  a_r7_ovf_with_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (valid_o || more_o));

  a_r8_idle_no_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(start_i) |-> !(valid_o || more_o));

  a_r8_idle_value_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(start_i) |-> ($stable(value_o) && $stable(ptr_o)));
endmodule

bind leb128_word_dec leb128_word_dec_chk #(.IN_BYTES(IN_BYTES), .OUT_BYTES(OUT_BYTES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .value_o (value_o),
  .ptr_o   (ptr_o),
  .more_o  (more_o),
  .ovf_o   (ovf_o),
  .valid_o (valid_o)
);

// File: tb/tb_leb128_word_dec.sv
`timescale 1ns/1ps
module tb_leb128_word_dec;
  localparam int unsigned NB    = 8;
  localparam int unsigned OB    = 4;
  localparam int unsigned PW    = $clog2(NB);
  localparam int unsigned OW    = 8 * OB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          cont = 1'b0;
  logic [8*NB-1:0] word = '0;
  logic [PW-1:0] ptr = '0;
  logic [OW-1:0] value;
  logic [PW-1:0] ptr_out;
  logic          more, ovf, valid;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  leb128_word_dec #(.IN_BYTES(NB), .OUT_BYTES(OB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cont_i(cont),
    .word_i(word), .ptr_i(ptr), .value_o(value), .ptr_o(ptr_out),
    .more_o(more), .ovf_o(ovf), .valid_o(valid)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  // one strobe, called at a negedge, returns at the next negedge
  task automatic strobe(input logic [8*NB-1:0] w, input int p, input bit c);
    start = 1'b1; cont = c; word = w; ptr = PW'(p);
    @(negedge clk);
    start = 1'b0;
  endtask

  // encode v (plus pad zero groups), place from p0, feed word by word and check each step
  task automatic run_num(input logic [63:0] v, input int pad, input int p0, input string tag);
    logic [7:0] bs [16];
    int g = 1, n, idx = 0, pos = p0, q;
    bit first = 1;
    logic [63:0] m, pv;
    while (g * 7 < 64 && (v >> (7 * g)) != 0) g++;
    n = g + pad;
    for (int i = 0; i < n; i++) begin
      bs[i][6:0] = (7 * i < 64) ? 7'(v >> (7 * i)) : 7'd0;
      bs[i][7]   = (i < n - 1);
    end
    forever begin
      logic [8*NB-1:0] w = rnd64();
      q = pos;
      while (q < NB && idx < n) begin
        w[8*q +: 8] = bs[idx];
        idx++; q++;
      end
      strobe(w, pos, !first);
      m  = (7 * idx >= 64) ? '1 : ((64'd1 << (7 * idx)) - 1);
      pv = v & m;
      chk(value == pv[OW-1:0], {tag, " R1 R2 R5 value"}, value, pv[OW-1:0]);
      chk(ovf == (|pv[63:OW]), {tag, " R7 ovf"}, ovf, |pv[63:OW]);
      if (idx == n) begin
        chk(valid && !more, {tag, " R8 valid"}, {valid, more}, 2'b10);
        chk(ptr_out == PW'(q % NB), {tag, " R3 ptr"}, ptr_out, q % NB);
        break;
      end
      chk(more && !valid, {tag, " R4 more"}, {valid, more}, 2'b01);
      chk(ptr_out == '0, {tag, " R4 ptr wrap"}, ptr_out, 0);
      pos = 0; first = 0;
    end
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] v, held;
    logic [8*NB-1:0] w;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk({value, ptr_out, more, ovf, valid} == '0, "R9 reset", {value, ptr_out, more, ovf, valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // single word, offset 3
    w = rnd64(); w[24 +: 24] = 24'h268EE5;
    strobe(w, 3, 0);
    chk(value == 32'h00098765, "R1 example value", value, 32'h00098765);
    chk(ptr_out == 3'd6, "R3 example ptr", ptr_out, 6);
    chk(valid && !more && !ovf, "R8 example flags", {valid, more, ovf}, 3'b100);

    // crossing the word end from offset 6
    w = rnd64(); w[48 +: 16] = 16'h8EE5;
    strobe(w, 6, 0);
    chk(value == 32'h765 && more && ptr_out == 0, "R4 split partial", {value, more, ptr_out}, {32'h765, 1'b1, 3'd0});
    w = rnd64(); w[7:0] = 8'h26;
    strobe(w, 0, 1);
    chk(value == 32'h00098765 && valid && ptr_out == 1, "R5 split resume", {value, valid, ptr_out}, {32'h98765, 1'b1, 3'd1});

    // idle cycle: flags drop, value holds
    held = 64'(value);
    @(negedge clk);
    chk(!valid && !more && !ovf && value == held[OW-1:0], "R8 idle hold", {valid, more, value}, held);

    // abandoned partial then fresh start
    w = rnd64(); w[56 +: 8] = 8'hFF;
    strobe(w, 7, 0);
    chk(more, "R4 abandon partial", more, 1);
    run_num(64'd5, 0, 2, "R6 fresh start");

    // overflow corners
    run_num(64'hFFFF_FFFF, 0, 0, "R7 max fit");
    run_num(64'h1_0000_0000, 0, 4, "R7 first overflow");
    run_num(64'hFFFF_FFFF_FFFF_FFFF, 0, 1, "R7 full 64");
    run_num(64'd0, 11, 7, "R7 padded zero");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int len = $urandom % 65;
      v = rnd64();
      if (len < 64) v = v & ((64'd1 << len) - 1);
      run_num(v, ($urandom % 4 == 0) ? int'($urandom % 3) : 0, int'($urandom % NB), "rnd");
      if ($urandom % 5 == 0) begin
        held = 64'(value);
        @(negedge clk);
        chk(!valid && !more && value == held[OW-1:0], "R8 rnd idle", {valid, more, value}, held);
      end
    end
    finish_run();
  end
endmodule